// File: doc/BRIEF.md
# 8-bit ALU with ZNCV flags

A combinational arithmetic-logic unit for a small 8-bit processor datapath. A 4-bit operation code selects the function. The unit combines the two operands and returns an 8-bit result with four status flags: zero (Z), negative (N), carry (C) and overflow (V). The available functions are addition, subtraction, compare, bitwise AND/OR/XOR, single-bit shifts in either direction, truncated multiply and unsigned divide. A pass-through function forwards operand A so that a byte fetched from memory can update Z and N.

The unit stores nothing and never writes anything back. The surrounding sequencer decides whether to keep the result and the flags. The unit does raise one hint output on compare, which marks the result as one that must not reach the register file. The operand width is a parameter and defaults to 8. The adder and the multiplier each come in two structural variants, chosen by parameters.

Top module: `zncv_alu`

## Requirements
- R1: Code 0x0 adds. The result is (A+B) mod 256. C=1 when A+B>0xFF. V=1 when A and B have the same bit 7 and the result's bit 7 differs from it.
- R2: Code 0x1 subtracts. The result is (A-B) mod 256. C=1 when A>=B unsigned, meaning no borrow. V=1 when A and B differ in bit 7 and the result's bit 7 differs from A's.
- R3: Code 0x9 (compare) produces the same result and flags as code 0x1. Output hold_wb_o is 1 for code 0x9 and 0 for every other code.
- R4: Codes 0x2, 0x3 and 0x4 give A AND B, A OR B and A XOR B, each with C=0 and V=0.
- R5: Code 0x5 shifts A left by one. A 0 enters bit 0, C takes A bit 7, V=0, and B has no effect.
- R6: Code 0x6 shifts A right by one. A 0 enters bit 7, C takes A bit 0, V=0, and B has no effect.
- R7: Code 0x7 returns the low 8 bits of A*B. C=1 when the full product exceeds 0xFF, and V=0.
- R8: Code 0x8 with B not zero returns the unsigned quotient A/B, truncated toward zero, with C=0 and V=0.
- R9: Code 0x8 with B equal to zero returns 0 with C=1 and V=1.
- R10: For every code, Z=1 exactly when the 8-bit result is 0, and N equals result bit 7.
- R11: Code 0xA and the unassigned codes 0xB to 0xF forward A as the result with C=0 and V=0. B has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opr_a | input | WIDTH | First operand; the shifted or forwarded value |
| opr_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| res_o | output | WIDTH | Computed result |
| z_o | output | 1 | Result is zero |
| n_o | output | 1 | Result most significant bit |
| c_o | output | 1 | Carry / no-borrow / shifted-out bit / product overflow / divide-by-zero |
| v_o | output | 1 | Signed overflow, or divide-by-zero |
| hold_wb_o | output | 1 | High on compare: result must not be written back |

## Verification
The unit holds no state. A wrong internal node, such as a broken carry link in the ripple chain or a wrong trial subtraction in a divider stage, shows at the ports in the same cycle as the operands that exercise it. The usual symptoms are a result bit that is wrong or a C/V flag that is wrong. The stimulus targets the operand pairs that propagate a carry across all bits, that cross the signed boundary 0x7F/0x80, that cause a borrow, that shift a 1 out of either end, and that divide by zero or by one. A wrong node on those paths is therefore seen on the first vector that reaches it.

// File: rtl/zncv_alu_pkg.sv
package zncv_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_AND  = 4'h2,
      OP_OR   = 4'h3,
      OP_XOR  = 4'h4,
      OP_SHL  = 4'h5,
      OP_SHR  = 4'h6,
      OP_MUL  = 4'h7,
      OP_DIV  = 4'h8,
      OP_CMP  = 4'h9,
      OP_PASS = 4'hA
   } op_e;

   // adder structure
   localparam int ADD_BEHAV  = 0;
   localparam int ADD_RIPPLE = 1;
   // multiplier structure
   localparam int MUL_BEHAV  = 0;
   localparam int MUL_ARRAY  = 1;

endpackage

// File: rtl/zncv_alu_addsub.sv
module zncv_alu_addsub
   import zncv_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int STYLE = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   generate
      if (STYLE == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
         end
         assign cout_o = cy[WIDTH];
      end else if (STYLE == ADD_BEHAV) begin : g_behav
         logic [WIDTH:0] full;
         assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
      end else begin : g_bad_style
         $error("zncv_alu_addsub: unknown STYLE %0d", STYLE);
      end
   endgenerate

   // signed overflow: both effective inputs agree in sign, result disagrees
   assign ovf_o = (a_i[MSB] ^ sum_o[MSB]) & (b_eff[MSB] ^ sum_o[MSB]);

endmodule

// File: rtl/zncv_alu_logic.sv
module zncv_alu_logic
   import zncv_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  op_e              op_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         default: res_o = a_i & b_i;
      endcase
   end
endmodule

// File: rtl/zncv_alu_shift.sv
module zncv_alu_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             right_i,
   output logic [WIDTH-1:0] res_o,
   output logic             out_bit_o
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      if (right_i) begin
         res_o     = {1'b0, a_i[MSB:1]};
         out_bit_o = a_i[0];
      end else begin
         res_o     = {a_i[MSB-1:0], 1'b0};
         out_bit_o = a_i[MSB];
      end
   end

   always_comb begin
      if (right_i) p_shr_fill_r6: assert (res_o[MSB] == 1'b0);
      else         p_shl_fill_r5: assert (res_o[0] == 1'b0);
   end
endmodule

// File: rtl/zncv_alu_muldiv.sv
module zncv_alu_muldiv
   import zncv_alu_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int MUL_STYLE = MUL_ARRAY
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] prod_lo_o,
   output logic             prod_wide_o,
   output logic [WIDTH-1:0] quot_o
);
   localparam int W2 = 2 * WIDTH;

   logic [W2-1:0] prod;

   generate
      if (MUL_STYLE == MUL_ARRAY) begin : g_array
         logic [W2-1:0] acc [WIDTH+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_pp
            assign acc[i+1] = acc[i] + (b_i[i] ? ({{WIDTH{1'b0}}, a_i} << i) : {W2{1'b0}});
         end
         assign prod = acc[WIDTH];
      end else if (MUL_STYLE == MUL_BEHAV) begin : g_behav
         assign prod = W2'(a_i) * W2'(b_i);
      end else begin : g_bad_style
         $error("zncv_alu_muldiv: unknown MUL_STYLE %0d", MUL_STYLE);
      end
   endgenerate

   assign prod_lo_o   = prod[WIDTH-1:0];
   assign prod_wide_o = |prod[W2-1:WIDTH];

   // restoring divider, one trial subtraction per quotient bit, MSB first
   logic [WIDTH-1:0] rem [WIDTH+1];
   assign rem[0] = '0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_div
      localparam int BIT = WIDTH - 1 - i;
      logic [WIDTH:0] trial;
      logic [WIDTH:0] diff;
      assign trial       = {rem[i], a_i[BIT]};
      assign diff        = trial - {1'b0, b_i};
      assign quot_o[BIT] = ~diff[WIDTH];
      assign rem[i+1]    = diff[WIDTH] ? trial[WIDTH-1:0] : diff[WIDTH-1:0];
   end

   always_comb begin
      if (b_i != '0) begin
         p_div_recon_r8: assert ((W2'(quot_o) * W2'(b_i) + W2'(rem[WIDTH])) == W2'(a_i));
         p_div_rem_r8:   assert (rem[WIDTH] < b_i);
      end
   end
endmodule

// File: rtl/zncv_alu.sv
module zncv_alu
   import zncv_alu_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int ADD_STYLE = ADD_RIPPLE,
   parameter int MUL_STYLE = MUL_ARRAY
) (
   input  logic [WIDTH-1:0] opr_a,
   input  logic [WIDTH-1:0] opr_b,
   input  logic [3:0]       op_sel,
   output logic [WIDTH-1:0] res_o,
   output logic             z_o,
   output logic             n_o,
   output logic             c_o,
   output logic             v_o,
   output logic             hold_wb_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("zncv_alu: WIDTH must be at least 2, got %0d", WIDTH);
      end
   endgenerate

   op_e op;
   assign op = op_e'(op_sel);

   logic             is_sub;
   logic [WIDTH-1:0] as_sum, lg_res, sh_res, mul_lo, div_q;
   logic             as_c, as_v, sh_c, mul_wide;

   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   zncv_alu_addsub #(.WIDTH(WIDTH), .STYLE(ADD_STYLE)) u_addsub (
      .a_i   (opr_a),
      .b_i   (opr_b),
      .sub_i (is_sub),
      .sum_o (as_sum),
      .cout_o(as_c),
      .ovf_o (as_v)
   );

   zncv_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i  (opr_a),
      .b_i  (opr_b),
      .op_i (op),
      .res_o(lg_res)
   );

   zncv_alu_shift #(.WIDTH(WIDTH)) u_shift (
      .a_i      (opr_a),
      .right_i  (op == OP_SHR),
      .res_o    (sh_res),
      .out_bit_o(sh_c)
   );

   zncv_alu_muldiv #(.WIDTH(WIDTH), .MUL_STYLE(MUL_STYLE)) u_muldiv (
      .a_i        (opr_a),
      .b_i        (opr_b),
      .prod_lo_o  (mul_lo),
      .prod_wide_o(mul_wide),
      .quot_o     (div_q)
   );

   always_comb begin
      res_o = opr_a;
      c_o   = 1'b0;
      v_o   = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_CMP: begin
            res_o = as_sum;
            c_o   = as_c;
            v_o   = as_v;
         end
         OP_AND, OP_OR, OP_XOR: res_o = lg_res;
         OP_SHL, OP_SHR: begin
            res_o = sh_res;
            c_o   = sh_c;
         end
         OP_MUL: begin
            res_o = mul_lo;
            c_o   = mul_wide;
         end
         OP_DIV: begin
            if (opr_b == '0) begin
               res_o = '0;
               c_o   = 1'b1;
               v_o   = 1'b1;
            end else begin
               res_o = div_q;
            end
         end
         default: ;
      endcase
   end

   assign z_o       = (res_o == '0);
   assign n_o       = res_o[MSB];
   assign hold_wb_o = (op == OP_CMP);

   always_comb begin
      if (op_sel == 4'h0) begin
         p_add_carry_r1: assert ({c_o, res_o} == ({1'b0, opr_a} + {1'b0, opr_b}));
         p_add_ovf_r1:   assert (v_o == (((opr_a ^ res_o) & (opr_b ^ res_o)) >> MSB));
      end
      if (op_sel == 4'h1 || op_sel == 4'h9) begin
         p_sub_carry_r2: assert (c_o == (opr_a >= opr_b));
         p_sub_ovf_r2:   assert (v_o == (((opr_a ^ opr_b) & (opr_a ^ res_o)) >> MSB));
      end
      if (hold_wb_o) p_hold_cmp_r3: assert (op_sel == 4'h9);
      if (op_sel >= 4'h2 && op_sel <= 4'h4) p_logic_cv_r4: assert (!c_o && !v_o);
      if (op_sel == 4'h5) p_shl_carry_r5: assert (c_o == opr_a[MSB] && !v_o);
      if (op_sel == 4'h6) p_shr_carry_r6: assert (c_o == opr_a[0] && !v_o);
      if (op_sel == 4'h7) p_mul_novf_r7: assert (!v_o);
      if (op_sel == 4'h8 && opr_b == '0) p_div_zero_r9: assert (res_o == '0 && c_o && v_o);
      if (op_sel == 4'h8 && opr_b != '0) p_div_flags_r8: assert (!c_o && !v_o);
      if (op_sel >= 4'hA) p_pass_r11: assert (res_o == opr_a && !c_o && !v_o);
   end

endmodule

// File: tb/zncv_alu_tb_top.sv
`timescale 1ns/1ps
module zncv_alu_tb_top;

   typedef struct {
      logic [7:0] a;
      logic [7:0] b;
      logic [3:0] op;
      logic [7:0] res;
      logic       z, n, c, v, hold;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opr_a = '0, opr_b = '0;
   logic [3:0] op_sel = '0;
   logic [7:0] res_o;
   logic       z_o, n_o, c_o, v_o, hold_wb_o;

   int   total = 0;
   int   bad   = 0;
   int   cycles = 0;
   bit   done = 0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   zncv_alu dut_i (
      .opr_a(opr_a), .opr_b(opr_b), .op_sel(op_sel),
      .res_o(res_o), .z_o(z_o), .n_o(n_o), .c_o(c_o), .v_o(v_o),
      .hold_wb_o(hold_wb_o)
   );

   function automatic exp_t model(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
      exp_t e;
      logic [15:0] p;
      e.a = a; e.b = b; e.op = op;
      e.c = 0; e.v = 0; e.res = a; e.req = "R11";
      case (op)
         4'h0: begin
            e.res = a + b; e.c = (int'(a) + int'(b)) > 255;
            e.v = (a[7] == b[7]) && (e.res[7] != a[7]); e.req = "R1";
         end
         4'h1, 4'h9: begin
            e.res = a - b; e.c = (a >= b);
            e.v = (a[7] != b[7]) && (e.res[7] != a[7]);
            e.req = (op == 4'h9) ? "R3" : "R2";
         end
         4'h2: begin e.res = a & b; e.req = "R4"; end
         4'h3: begin e.res = a | b; e.req = "R4"; end
         4'h4: begin e.res = a ^ b; e.req = "R4"; end
         4'h5: begin e.res = {a[6:0], 1'b0}; e.c = a[7]; e.req = "R5"; end
         4'h6: begin e.res = {1'b0, a[7:1]}; e.c = a[0]; e.req = "R6"; end
         4'h7: begin
            p = 16'(a) * 16'(b); e.res = p[7:0]; e.c = (p > 16'd255); e.req = "R7";
         end
         4'h8: begin
            if (b == 0) begin e.res = 0; e.c = 1; e.v = 1; e.req = "R9"; end
            else begin e.res = a / b; e.req = "R8"; end
         end
         default: ;
      endcase
      e.z = (e.res == 0);
      e.n = e.res[7];
      e.hold = (op == 4'h9);
      return e;
   endfunction

   task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
      @(posedge clk);
      #1;
      opr_a = a; opr_b = b; op_sel = op;
      sb_q.push_back(model(a, b, op));
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp, input exp_t e);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s op=%h a=%h b=%h actual=%h expected=%h",
                  req, what, e.op, e.a, e.b, act, exp);
      end
   endtask

   // monitor: sample mid-cycle, pop and compare
   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(res_o == e.res, e.req, "result", res_o, e.res, e);
         check({c_o, v_o} == {e.c, e.v}, e.req, "cv", {c_o, v_o}, {e.c, e.v}, e);
         check({z_o, n_o} == {e.z, e.n}, "R10", "zn", {z_o, n_o}, {e.z, e.n}, e);
         check(hold_wb_o == e.hold, "R3", "hold", hold_wb_o, e.hold, e);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-state inputs: zero add gives zero result with Z (R10)
      send(8'h00, 8'h00, 4'h0);
      // R1 corners
      send(8'h7F, 8'h01, 4'h0);
      send(8'hFF, 8'h01, 4'h0);
      send(8'h80, 8'h80, 4'h0);
      // R2 corners
      send(8'h80, 8'h01, 4'h1);
      send(8'h05, 8'h07, 4'h1);
      send(8'h42, 8'h42, 4'h1);
      // R3 compare
      send(8'h05, 8'h07, 4'h9);
      send(8'h7F, 8'hFF, 4'h9);
      // R4 logic
      send(8'hF0, 8'h3C, 4'h2);
      send(8'hF0, 8'h0F, 4'h3);
      send(8'hAA, 8'hAA, 4'h4);
      // R5 / R6 shifts, B must not matter
      send(8'h81, 8'h00, 4'h5);
      send(8'h81, 8'hFF, 4'h5);
      send(8'h81, 8'h00, 4'h6);
      send(8'h81, 8'hFF, 4'h6);
      send(8'h01, 8'h5A, 4'h6);
      // R7 multiply
      send(8'h10, 8'h10, 4'h7);
      send(8'h0F, 8'h11, 4'h7);
      send(8'hFF, 8'hFF, 4'h7);
      // R8 / R9 divide
      send(8'hFF, 8'h01, 4'h8);
      send(8'h07, 8'h08, 4'h8);
      send(8'hC8, 8'h07, 4'h8);
      send(8'h10, 8'h00, 4'h8);
      send(8'h00, 8'h00, 4'h8);
      // R11 pass and unassigned codes, B varied
      for (int k = 10; k < 16; k++) begin
         send(8'h80, 8'h00, 4'(k));
         send(8'h80, 8'hFF, 4'(k));
         send(8'h00, 8'h37, 4'(k));
      end
      // sweep every code with spread operands
      for (int op = 0; op < 16; op++) begin
         for (int k = 0; k < 16; k++) begin
            send(8'(k * 37 + op * 11 + 3), 8'(k * 53 + 7 * op), 4'(op));
         end
      end
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule